// File: doc/BRIEF.md
# Operand Pairing Unit with Overflow Stack

This block is the pairing stage of a dataflow processor. Each arriving token carries a color (the activation tag), a destination (the consuming instruction), a side bit that says whether it is the left or the right operand, and a data word. The unit looks for a waiting token with the same color and destination on the opposite side. On a hit, both data words leave together as one pair, left operand first, and the waiting entry is freed. On a miss, the token is parked in a fixed-size pairing store until its partner arrives.

When the pairing store is full and the token finds no partner, it is pushed onto a side stack instead. The stack is addressed by a single up/down counter, so spilled tokens come back last in, first out. As soon as the store has a free slot again, the top of the stack is taken back and paired or stored before any new input is accepted. The stack can be left out at build time with a parameter. Without it, a full store with no partner simply holds off the upstream producer.

The control is a two-state machine. In ACCEPT, each cycle processes one candidate: the stack top when a drain is due, otherwise the input token. The transition ACCEPT to EMIT is taken when the candidate hits and the pair is loaded into the output register. The transition EMIT to ACCEPT is taken when the consumer takes the pair. In all other cases each state stays where it is.

Top module: `token_match_unit`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, store_full is 0 and spill_empty is 1.
- R2: A token whose color and destination equal those of a waiting token, with the opposite side bit (0 = left, 1 = right), produces one pair with out_lhs = data of the side-0 token and out_rhs = data of the side-1 token, whichever arrived first. A token with the same destination but a different color does not pair.
- R3: A token that finds no partner while the store has a free slot is kept and produces no output.
- R4: store_full is 1 exactly while all NSLOT (default 32) store slots are occupied, and drops again when a pairing frees one.
- R5: A token that finds no partner while the store is full is pushed onto the overflow stack; spill_empty goes to 0 and stays 0 until the stack is drained.
- R6: Stacked tokens return to the store in last-in, first-out order.
- R7: While the stack is non-empty and the store has a free slot, in_ready is 0 and the stack top is processed before any new input.
- R8: With the store full and the stack holding SPILL_DEPTH tokens, an unpaired input sees in_ready = 0; an input that pairs with a stored token is still accepted.
- R9: While out_valid is 1 and out_ready is 0, the pair outputs hold their values and in_ready is 0.
- R10: With SPILL_EN = 0, spill_empty stays 1, a full store holds off an unpaired input with in_ready = 0, and a pairing input is still accepted and paired.
- R11: An input that pairs with a stored token is paired even while the store is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Input token taken at this edge when in_valid is 1 |
| in_color | input | CW | Activation tag of the input token |
| in_dest | input | DW | Destination instruction of the input token |
| in_side | input | 1 | 0 = left operand, 1 = right operand |
| in_data | input | XW | Operand value |
| out_valid | output | 1 | A pair is waiting on the outputs |
| out_ready | input | 1 | Consumer takes the pair at this edge |
| out_color | output | CW | Tag of the pair |
| out_dest | output | DW | Destination of the pair |
| out_lhs | output | XW | Left operand |
| out_rhs | output | XW | Right operand |
| store_full | output | 1 | All store slots occupied |
| spill_empty | output | 1 | Overflow stack holds no tokens |

## Verification
Two functions that meet in one cycle are the stack drain and a new input: when a pairing frees a slot while tokens sit on the stack, the next ACCEPT cycle has both a drain due and, possibly, a valid input. The bench provokes this by filling the store, stacking eight tokens, then sending a partner for a stored token and holding a new token right behind it; it judges that in_ready stays low in the drain cycle with store_full low and spill_empty low, and that the following partners of the stacked tokens pair in reverse push order, which only holds if the drained token entered the store before new input. A second overlap, a hit while the store is full, is judged by the pair appearing instead of a stall.

// File: rtl/token_match_pkg.sv
package token_match_pkg;

    // Control states of the pairing unit
    typedef enum logic {
        MS_ACCEPT = 1'b0,
        MS_EMIT   = 1'b1
    } match_state_e;

    // Candidate source chosen by the feedback select
    typedef enum logic {
        SRC_INPUT = 1'b0,
        SRC_SPILL = 1'b1
    } src_sel_e;

endpackage

// File: rtl/match_store.sv
module match_store #(
    parameter int NSLOT = 32,
    parameter int KW    = 10,
    parameter int XW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [KW-1:0] probe_key,
    input  logic          probe_side,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_data,
    input  logic          clr_en,
    output logic          hit,
    output logic [XW-1:0] hit_data,
    output logic          full
);
    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [NSLOT-1:0] vld_q;
    logic [NSLOT-1:0] hit_vec;
    logic [KW-1:0]    key_q  [NSLOT];
    logic             side_q [NSLOT];
    logic [XW-1:0]    data_q [NSLOT];
    logic [IW-1:0]    hit_idx;
    logic [IW-1:0]    free_idx;

    // One comparator per slot: same key, opposite side
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (key_q[g] == probe_key) && (side_q[g] != probe_side);
    end

    // Lowest-index hit and lowest-index free slot
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
            if (!vld_q[i])  free_idx = IW'(i);
        end
    end

    assign hit      = |hit_vec;
    assign full     = &vld_q;
    assign hit_data = data_q[hit_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (wr_en && !full) vld_q[free_idx] <= 1'b1;
            if (clr_en && hit)  vld_q[hit_idx]  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            key_q[free_idx]  <= probe_key;
            side_q[free_idx] <= probe_side;
            data_q[free_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/spill_stack.sv
module spill_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 19,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] ptr_q;
    logic [CW-1:0] below_top;

    // Up/down counter is the stack address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push && !full) begin
            ptr_q <= ptr_q + CW'(1);
        end else if (pop && !empty) begin
            ptr_q <= ptr_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[ptr_q[IW-1:0]] <= din;
    end

    assign below_top = ptr_q - CW'(1);
    assign top       = mem[below_top[IW-1:0]];
    assign empty     = (ptr_q == '0);
    assign full      = (ptr_q == CW'(DEPTH));
    assign count     = ptr_q;

endmodule

// File: rtl/token_match_unit.sv
module token_match_unit
    import token_match_pkg::*;
#(
    parameter int CW          = 3,
    parameter int DW          = 7,
    parameter int XW          = 8,
    parameter int NSLOT       = 32,
    parameter int SPILL_EN    = 1,
    parameter int SPILL_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] in_color,
    input  logic [DW-1:0] in_dest,
    input  logic          in_side,
    input  logic [XW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [CW-1:0] out_color,
    output logic [DW-1:0] out_dest,
    output logic [XW-1:0] out_lhs,
    output logic [XW-1:0] out_rhs,
    output logic          store_full,
    output logic          spill_empty
);
    localparam int KW  = CW + DW;
    localparam int TW  = KW + 1 + XW;
    localparam int SCW = $clog2(SPILL_DEPTH + 1);

    match_state_e   state_q, state_d;
    src_sel_e       src_sel;

    logic [TW-1:0]  in_tok, spill_top, cand;
    logic [KW-1:0]  cand_key;
    logic           cand_side;
    logic [XW-1:0]  cand_data;
    logic           drain, hit, full, sp_empty, sp_full;
    logic [XW-1:0]  hit_data;
    logic [SCW-1:0] spill_cnt;
    logic           st_wr, st_clr, sp_push, sp_pop, ld_out, rdy;

    assign in_tok = {in_color, in_dest, in_side, in_data};

    // Drain is due whenever the stack holds tokens and a slot is free
    assign drain = (state_q == MS_ACCEPT) && !sp_empty && !full;

    // Feedback select: stack top versus input token
    always_comb begin
        src_sel = drain ? SRC_SPILL : SRC_INPUT;
        unique case (src_sel)
            SRC_SPILL: cand = spill_top;
            SRC_INPUT: cand = in_tok;
            default:   cand = in_tok;
        endcase
    end

    assign cand_key  = cand[TW-1 -: KW];
    assign cand_side = cand[XW];
    assign cand_data = cand[XW-1:0];

    match_store #(
        .NSLOT (NSLOT),
        .KW    (KW),
        .XW    (XW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_key  (cand_key),
        .probe_side (cand_side),
        .wr_en      (st_wr),
        .wr_data    (cand_data),
        .clr_en     (st_clr),
        .hit        (hit),
        .hit_data   (hit_data),
        .full       (full)
    );

    if (SPILL_EN != 0) begin : g_spill
        spill_stack #(
            .DEPTH (SPILL_DEPTH),
            .W     (TW)
        ) u_stack (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (sp_push),
            .pop   (sp_pop),
            .din   (in_tok),
            .top   (spill_top),
            .empty (sp_empty),
            .full  (sp_full),
            .count (spill_cnt)
        );
    end else begin : g_nospill
        logic spill_unused;
        assign spill_unused = sp_push ^ sp_pop;
        assign spill_top    = '0;
        assign sp_empty     = 1'b1;
        assign sp_full      = 1'b1;
        assign spill_cnt    = '0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_ACCEPT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_ACCEPT: if (ld_out)    state_d = MS_EMIT;
            MS_EMIT:   if (out_ready) state_d = MS_ACCEPT;
            default:                  state_d = MS_ACCEPT;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        rdy       = 1'b0;
        out_valid = 1'b0;
        st_wr     = 1'b0;
        st_clr    = 1'b0;
        sp_push   = 1'b0;
        sp_pop    = 1'b0;
        ld_out    = 1'b0;
        unique case (state_q)
            MS_ACCEPT: begin
                rdy    = !drain && (hit || !full || (SPILL_EN != 0 && !sp_full));
                sp_pop = drain;
                if (drain || (in_valid && rdy)) begin
                    if (hit) begin
                        st_clr = 1'b1;
                        ld_out = 1'b1;
                    end else if (!full) begin
                        st_wr = 1'b1;
                    end else begin
                        sp_push = 1'b1;
                    end
                end
            end
            MS_EMIT: out_valid = 1'b1;
            default: ;
        endcase
    end

    assign in_ready = rdy;

    // Pair register, left operand first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_color <= '0;
            out_dest  <= '0;
            out_lhs   <= '0;
            out_rhs   <= '0;
        end else if (ld_out) begin
            out_color <= cand[TW-1 -: CW];
            out_dest  <= cand[TW-CW-1 -: DW];
            out_lhs   <= cand_side ? hit_data : cand_data;
            out_rhs   <= cand_side ? cand_data : hit_data;
        end
    end

    assign store_full  = full;
    assign spill_empty = sp_empty;

endmodule

// File: rtl/token_match_chk.sv
module token_match_chk #(
    parameter int CW  = 3,
    parameter int DW  = 7,
    parameter int XW  = 8,
    parameter int SCW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [CW-1:0]  out_color,
    input logic [DW-1:0]  out_dest,
    input logic [XW-1:0]  out_lhs,
    input logic [XW-1:0]  out_rhs,
    input logic           store_full,
    input logic           spill_empty,
    input logic [SCW-1:0] spill_cnt
);
    // R9
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_lhs) && $stable(out_rhs)
                                    && $stable(out_color) && $stable(out_dest));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R7
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !spill_empty && !store_full |-> !in_ready);

    // R5
    push_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spill_cnt > $past(spill_cnt) |-> $past(store_full));

    // R6
    pop_only_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spill_cnt < $past(spill_cnt) |-> !$past(store_full));

endmodule

bind token_match_unit token_match_chk #(
    .CW  (CW),
    .DW  (DW),
    .XW  (XW),
    .SCW (SCW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_color   (out_color),
    .out_dest    (out_dest),
    .out_lhs     (out_lhs),
    .out_rhs     (out_rhs),
    .store_full  (store_full),
    .spill_empty (spill_empty),
    .spill_cnt   (spill_cnt)
);

// File: tb/sim_token_match_unit.sv
module sim_token_match_unit;

    localparam int NS = 32;

    typedef struct packed {
        logic [2:0] c;
        logic [6:0] d;
        logic       s;
        logic [7:0] x;
    } tok_t;

    typedef struct packed {
        logic [2:0] c;
        logic [6:0] d;
        logic [7:0] l;
        logic [7:0] r;
    } pair_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst_n;

    logic       in_valid, in_ready, in_side, out_valid, out_ready, store_full, spill_empty;
    logic [2:0] in_color, out_color;
    logic [6:0] in_dest, out_dest;
    logic [7:0] in_data, out_lhs, out_rhs;

    logic       b_in_valid, b_in_ready, b_in_side, b_out_valid, b_store_full, b_spill_empty;
    logic [2:0] b_in_color, b_out_color;
    logic [6:0] b_in_dest, b_out_dest;
    logic [7:0] b_in_data, b_out_lhs, b_out_rhs;

    token_match_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_color(in_color), .in_dest(in_dest),
        .in_side(in_side), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_color(out_color), .out_dest(out_dest),
        .out_lhs(out_lhs), .out_rhs(out_rhs), .store_full(store_full), .spill_empty(spill_empty)
    );

    token_match_unit #(.NSLOT(4), .SPILL_EN(0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(b_in_valid), .in_ready(b_in_ready), .in_color(b_in_color), .in_dest(b_in_dest),
        .in_side(b_in_side), .in_data(b_in_data),
        .out_valid(b_out_valid), .out_ready(1'b1), .out_color(b_out_color), .out_dest(b_out_dest),
        .out_lhs(b_out_lhs), .out_rhs(b_out_rhs), .store_full(b_store_full), .spill_empty(b_spill_empty)
    );

    int    nvec = 0;
    int    nerr = 0;
    bit    finished = 1'b0;
    bit    rdy_rand = 1'b0;
    string cur_tag = "R2";
    tok_t  st_q[$];
    tok_t  sp_q[$];
    pair_t exp_q[$];
    string tag_q[$];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    function automatic tok_t mk(int c, int d, int s, int x);
        tok_t t;
        t.c = 3'(c); t.d = 7'(d); t.s = 1'(s); t.x = 8'(x);
        return t;
    endfunction

    // Reference pairing: search waiting tokens, queue the expected pair
    function automatic bit model_match(tok_t t);
        for (int i = 0; i < st_q.size(); i++) begin
            if (st_q[i].c == t.c && st_q[i].d == t.d && st_q[i].s != t.s) begin
                pair_t p;
                p.c = t.c;
                p.d = t.d;
                p.l = t.s ? st_q[i].x : t.x;
                p.r = t.s ? t.x : st_q[i].x;
                exp_q.push_back(p);
                tag_q.push_back(cur_tag);
                st_q.delete(i);
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic model_apply(tok_t t);
        if (!model_match(t)) begin
            if (st_q.size() < NS) st_q.push_back(t);
            else                  sp_q.push_back(t);
        end
        while (sp_q.size() > 0 && st_q.size() < NS) begin
            tok_t p;
            p = sp_q.pop_back();
            if (!model_match(p)) st_q.push_back(p);
        end
    endtask

    // Driver: present a token, wait for acceptance, update the model
    task automatic send(tok_t t);
        int w;
        @(negedge clk);
        in_color = t.c; in_dest = t.d; in_side = t.s; in_data = t.x;
        in_valid = 1'b1;
        #1;
        w = 0;
        while (!in_ready && w < 300) begin
            @(negedge clk);
            #1;
            w++;
        end
        if (!in_ready) begin
            chk(1'b0, cur_tag, "token never accepted", 0, 1);
            in_valid = 1'b0;
            return;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
        model_apply(t);
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        while ((exp_q.size() > 0 || out_valid) && w < 3000) begin
            @(negedge clk);
            w++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, cur_tag, "pairs still outstanding", exp_q.size(), 0);
    endtask

    // Monitor: consumer readiness, scoreboard compare, hold check
    initial begin
        logic [7:0] lfsr;
        bit         stalled;
        pair_t      snap;
        lfsr      = 8'h5a;
        stalled   = 1'b0;
        snap      = '0;
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            if (rdy_rand) begin
                lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                out_ready = lfsr[0];
            end else begin
                out_ready = 1'b1;
            end
            #2;
            if (stalled) begin
                // R9 outputs held through a stall, input held off
                chk(out_valid && {out_color, out_dest, out_lhs, out_rhs} == snap && !in_ready,
                    "R9", "pair held during stall", {out_valid, out_color, out_dest, out_lhs, out_rhs},
                    {1'b1, snap});
            end
            stalled = 1'b0;
            if (out_valid && out_ready) begin
                pair_t got;
                got = {out_color, out_dest, out_lhs, out_rhs};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected pair", got, 0);
                end else begin
                    pair_t e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(got == e, tg, "pair {color,dest,lhs,rhs}", got, e);
                end
            end else if (out_valid) begin
                stalled = 1'b1;
                snap    = {out_color, out_dest, out_lhs, out_rhs};
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_color = '0; in_dest = '0; in_side = 1'b0; in_data = '0;
        b_in_valid = 1'b0; b_in_color = '0; b_in_dest = '0; b_in_side = 1'b0; b_in_data = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(in_ready == 1'b1,    "R1", "in_ready", in_ready, 1);
        chk(out_valid == 1'b0,   "R1", "out_valid", out_valid, 0);
        chk(store_full == 1'b0,  "R1", "store_full", store_full, 0);
        chk(spill_empty == 1'b1, "R1", "spill_empty", spill_empty, 1);

        // R2 and R3: basic pairing and waiting
        cur_tag = "R2";
        send(mk(1, 5, 0, 8'h11));
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R3", "lone token gives no pair", out_valid, 0);
        send(mk(1, 5, 1, 8'h22));
        send(mk(2, 9, 1, 8'h33));
        send(mk(2, 9, 0, 8'h44));
        send(mk(3, 4, 0, 8'h55));
        send(mk(4, 4, 1, 8'h66));
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R2", "different color does not pair", out_valid, 0);
        send(mk(3, 4, 1, 8'h77));
        send(mk(4, 4, 0, 8'h88));
        wait_idle();

        // R4: fill the store
        cur_tag = "R4";
        for (int i = 0; i < NS; i++) send(mk(1, i, 0, i + 1));
        wait_idle();
        #1;
        chk(store_full == 1'b1,  "R4", "store_full after fill", store_full, 1);
        chk(spill_empty == 1'b1, "R4", "spill_empty after fill", spill_empty, 1);

        // R11: pairing against a full store
        cur_tag = "R11";
        send(mk(1, 0, 1, 8'ha0));
        wait_idle();
        #1;
        chk(store_full == 1'b0, "R4", "store_full drops after pairing", store_full, 0);
        send(mk(1, 0, 0, 8'h31));
        repeat (2) @(negedge clk);
        #1;
        chk(store_full == 1'b1, "R4", "store_full after refill", store_full, 1);

        // R5: spill onto the stack
        cur_tag = "R5";
        for (int j = 0; j < 8; j++) send(mk(2, j, 0, 8'hc0 + j));
        repeat (2) @(negedge clk);
        #1;
        chk(spill_empty == 1'b0, "R5", "spill_empty after spill", spill_empty, 0);
        chk(store_full == 1'b1,  "R5", "store stays full", store_full, 1);

        // R8: both full, unpaired token held off; pairing token accepted
        @(negedge clk);
        in_color = 3'd3; in_dest = 7'd0; in_side = 1'b0; in_data = 8'h99; in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R8", "in_ready with both full", in_ready, 0);
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R8", "in_ready still low", in_ready, 0);
        chk(out_valid == 1'b0, "R8", "no pair from held token", out_valid, 0);
        in_color = 3'd1; in_dest = 7'd1; in_side = 1'b1; in_data = 8'hb1;
        #1;
        chk(in_ready == 1'b1, "R8", "pairing token accepted", in_ready, 1);
        in_valid = 1'b0;
        cur_tag = "R8";
        send(mk(1, 1, 1, 8'hb1));

        // R7: drain cycle blocks input
        in_color = 3'd6; in_dest = 7'd6; in_side = 1'b0; in_data = 8'h66; in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0 && store_full == 1'b0 && spill_empty == 1'b0, "R7",
            "{in_ready,store_full,spill_empty} in drain cycle",
            {in_ready, store_full, spill_empty}, 3'b000);
        in_valid = 1'b0;
        wait_idle();

        // R6: stacked tokens come back newest first
        cur_tag = "R6";
        for (int j = 7; j >= 0; j--) send(mk(2, j, 1, 8'hd0 + j));
        wait_idle();
        #1;
        chk(spill_empty == 1'b1, "R6", "stack empty after drain", spill_empty, 1);

        // R9: random consumer stalls while emptying the store
        cur_tag = "R9";
        rdy_rand = 1'b1;
        send(mk(1, 0, 1, 8'he0));
        for (int i = 2; i < NS; i++) send(mk(1, i, 1, 8'h40 + i));
        wait_idle();
        rdy_rand = 1'b0;
        #1;
        chk(store_full == 1'b0 && spill_empty == 1'b1, "R9", "{store_full,spill_empty} at end",
            {store_full, spill_empty}, 2'b01);
        chk(st_q.size() == 0 && sp_q.size() == 0, "R9", "model drained", st_q.size(), 0);

        // R10: build without overflow stack
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            b_in_color = 3'd5; b_in_dest = 7'(i); b_in_side = 1'b0; b_in_data = 8'(i + 2);
            b_in_valid = 1'b1;
            #1;
            chk(b_in_ready == 1'b1, "R10", "fill accepted", b_in_ready, 1);
            @(posedge clk);
            #1 b_in_valid = 1'b0;
        end
        @(negedge clk);
        #1;
        chk(b_store_full == 1'b1 && b_spill_empty == 1'b1, "R10", "{store_full,spill_empty}",
            {b_store_full, b_spill_empty}, 2'b11);
        b_in_color = 3'd5; b_in_dest = 7'd9; b_in_side = 1'b0; b_in_data = 8'h12; b_in_valid = 1'b1;
        #1;
        chk(b_in_ready == 1'b0, "R10", "unpaired token held off", b_in_ready, 0);
        repeat (3) @(negedge clk);
        #1;
        chk(b_in_ready == 1'b0 && b_spill_empty == 1'b1, "R10", "still held, no stack",
            {b_in_ready, b_spill_empty}, 2'b01);
        b_in_dest = 7'd2; b_in_side = 1'b1; b_in_data = 8'h77;
        #1;
        chk(b_in_ready == 1'b1, "R10", "pairing token accepted", b_in_ready, 1);
        @(posedge clk);
        #1 b_in_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(b_out_valid == 1'b1 && b_out_lhs == 8'h04 && b_out_rhs == 8'h77 && b_out_dest == 7'd2,
            "R10", "{valid,lhs,rhs}", {b_out_valid, b_out_lhs, b_out_rhs}, {1'b1, 8'h04, 8'h77});
        @(negedge clk);
        #1;
        chk(b_store_full == 1'b0, "R10", "slot freed", b_store_full, 0);

        finish_up();
    end

endmodule